// File: doc/BRIEF.md
# Binary Calendar Time Counter

This block holds the time of day and the calendar date as plain binary fields: second, minute, hour, day of week, day of month, month and a two-digit year counted from 2000. It moves forward only when a one-second increment pulse arrives from an external prescaler. Carries ripple from seconds up through minutes, hours, days and months into the year. The day of week steps alongside the day of month. The day-of-month limit depends on the month, and February follows a leap-year rule.

A host reaches every field through a simple register port: a 6-bit address, 8-bit write data with a write enable, and an 8-bit read bus that reflects the addressed field in the same cycle. Four one-cycle strobes mark the start of a new minute, hour, day and month, for use by a separate interrupt unit.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the fields hold second 0, minute 0, hour 0, day of week 0, day 1, month 1 and year 0, and all four strobes are low.
- R2: Address 0 selects the second, 1 the minute, 2 the hour, 3 the day of week, 4 the day of month, 5 the month and 6 the year. A write stores the 8-bit binary value, and `rdata` shows the addressed field combinationally. Addresses 7 to 63 read as 0, and writes to them change no field.
- R3: No field changes in a cycle without an increment pulse or a write to it.
- R4: Each increment pulse adds one second. Seconds wrap 59 to 0 and carry into minutes. Minutes wrap 59 to 0 and carry into hours. Hours wrap 23 to 0 and carry into the day of month and the day of week.
- R5: The day of month wraps to 1 and carries into the month after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12.
- R6: February (month 2) ends after day 29 when the year is divisible by 4, including year 0, and after day 28 otherwise.
- R7: The day of week advances on every day carry and wraps 6 to 0.
- R8: The month wraps 12 to 1 and carries into the year. The year wraps 99 to 0.
- R9: An out-of-range value is stored as written. The next carry into that field sets it to its minimum and carries onward. A month outside 1 to 12 gives a 31-day month.
- R10: A write in the same cycle as an increment pulse is taken, and that pulse is dropped: no field advances.
- R11: `new_minute`, `new_hour`, `new_day` and `new_month` pulse for one cycle, in the cycle after the pulse that causes the seconds, minute, hour and day-of-month carry. `new_month` marks the day of month returning to 1 by counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-second increment pulse from the prescaler |
| we | input | 1 | Register write enable |
| addr | input | 6 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for the addressed field |
| new_minute | output | 1 | Strobe: seconds carried into minutes |
| new_hour | output | 1 | Strobe: minutes carried into hours |
| new_day | output | 1 | Strobe: hours carried into the date |
| new_month | output | 1 | Strobe: day of month rolled back to 1 |

## Verification
On every cycle, the assertions check four things. Fields stay stable without a pulse or a write. A write lands exactly as given. A field at or past its limit drops to its minimum. The strobes nest with the right fields at zero or one, and a colliding write suppresses the pulse. Only the bench scenarios can show the calendar itself: the month-dependent day limit, the leap-year February, the year wrap, and the end-to-end agreement of all seven fields after long random mixes of pulses and writes, including out-of-range values.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int CAL_DW = 8;
  localparam int CAL_NF = 7;

  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DOW = 3;
  localparam int F_DAY = 4;
  localparam int F_MON = 5;
  localparam int F_YR  = 6;

  // Last in-range value of each field (day uses a computed limit instead).
  function automatic logic [CAL_DW-1:0] fld_max(int idx);
    case (idx)
      F_SEC, F_MIN: return CAL_DW'(59);
      F_HR:         return CAL_DW'(23);
      F_DOW:        return CAL_DW'(6);
      F_DAY:        return CAL_DW'(31);
      F_MON:        return CAL_DW'(12);
      default:      return CAL_DW'(99);
    endcase
  endfunction

  // First in-range value; also the reset value.
  function automatic logic [CAL_DW-1:0] fld_min(int idx);
    if (idx == F_DAY || idx == F_MON) return CAL_DW'(1);
    return '0;
  endfunction

  function automatic logic leap_year(logic [CAL_DW-1:0] yr);
    return (yr[1:0] == 2'b00);
  endfunction

  function automatic logic [CAL_DW-1:0] month_days(logic [CAL_DW-1:0] mon,
                                                   logic [CAL_DW-1:0] yr);
    case (mon)
      CAL_DW'(2):                          return leap_year(yr) ? CAL_DW'(29) : CAL_DW'(28);
      CAL_DW'(4), CAL_DW'(6), CAL_DW'(9),
      CAL_DW'(11):                         return CAL_DW'(30);
      default:                             return CAL_DW'(31);
    endcase
  endfunction
endpackage

// File: rtl/cal_field.sv
module cal_field #(
  parameter int             DW   = 8,
  parameter logic [DW-1:0]  MINV = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic [DW-1:0] lim,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] val,
  output logic          last
);
  // At or beyond the limit: the next step wraps and carries.
  assign last = (val >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)      val <= MINV;
    else if (wr_en)  val <= wr_val;
    else if (inc)    val <= last ? MINV : val + 1'b1;
  end

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !wr_en |=> $stable(val)); // R3
  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> val == $past(wr_val)); // R2
  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    inc && last && !wr_en |=> val == MINV); // R9
  AST_FIELD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !last && !wr_en |=> val > $past(val)); // R4
endmodule

// File: rtl/cal_readmux.sv
module cal_readmux #(
  parameter int NF = 7,
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic [NF-1:0][DW-1:0] fields,
  input  logic [AW-1:0]         addr,
  output logic [DW-1:0]         rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NF; i++)
      if (addr == AW'(i)) rdata = fields[i];
  end
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
  import cal_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = CAL_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          new_minute,
  output logic          new_hour,
  output logic          new_day,
  output logic          new_month
);
  localparam int NF = CAL_NF;

  logic [NF-1:0][DW-1:0] fval;
  logic [NF-1:0][DW-1:0] flim;
  logic [NF-1:0]         fwr;
  logic [NF-1:0]         finc;
  logic [NF-1:0]         flast;

  // Named internal events for assertions.
  logic tick_eff;
  logic c_sec, c_min, c_hr, c_day, c_mon;

  assign tick_eff = tick_1hz && !we;   // a write steals the pulse
  assign c_sec = tick_eff && flast[F_SEC];
  assign c_min = c_sec    && flast[F_MIN];
  assign c_hr  = c_min    && flast[F_HR];
  assign c_day = c_hr     && flast[F_DAY];
  assign c_mon = c_day    && flast[F_MON];

  always_comb begin
    finc        = '0;
    finc[F_SEC] = tick_eff;
    finc[F_MIN] = c_sec;
    finc[F_HR]  = c_min;
    finc[F_DOW] = c_hr;
    finc[F_DAY] = c_hr;
    finc[F_MON] = c_day;
    finc[F_YR]  = c_mon;
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign fwr[i] = we && (addr == AW'(i));
    if (i == F_DAY) begin : g_dyn
      assign flim[i] = month_days(fval[F_MON], fval[F_YR]);
    end else begin : g_fix
      assign flim[i] = fld_max(i);
    end
    cal_field #(.DW(DW), .MINV(fld_min(i))) u_fld (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (finc[i]),
      .lim    (flim[i]),
      .wr_en  (fwr[i]),
      .wr_val (wdata),
      .val    (fval[i]),
      .last   (flast[i])
    );
  end

  cal_readmux #(.NF(NF), .AW(AW), .DW(DW)) u_rd (
    .fields (fval),
    .addr   (addr),
    .rdata  (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_minute <= 1'b0;
      new_hour   <= 1'b0;
      new_day    <= 1'b0;
      new_month  <= 1'b0;
    end else begin
      new_minute <= c_sec;
      new_hour   <= c_min;
      new_day    <= c_hr;
      new_month  <= c_day;
    end
  end

  AST_MIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    new_minute |-> fval[F_SEC] == '0); // R11
  AST_HOUR_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    new_hour |-> new_minute && fval[F_MIN] == '0); // R4
  AST_DAY_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    new_day |-> new_hour && fval[F_HR] == '0); // R4
  AST_MONTH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    new_month |-> new_day && fval[F_DAY] == DW'(1)); // R5
  AST_DOW_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    c_hr |=> fval[F_DOW] != $past(fval[F_DOW])); // R7
  AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    we && tick_1hz && addr != AW'(F_SEC) |=> $stable(fval[F_SEC])); // R10
endmodule

// File: tb/sim_cal_time_counter.sv
`timescale 1ns/1ps
module sim_cal_time_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       new_minute, new_hour, new_day, new_month;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int m [7];
  int es [4];

  always #5 clk = ~clk;

  cal_time_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .new_minute(new_minute), .new_hour(new_hour),
    .new_day(new_day), .new_month(new_month)
  );

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // Reference step written as a cascade of rollovers.
  task automatic model_tick();
    es = '{0, 0, 0, 0};
    if (m[0] < 59) begin m[0]++; return; end
    m[0] = 0; es[0] = 1;
    if (m[1] < 59) begin m[1]++; return; end
    m[1] = 0; es[1] = 1;
    if (m[2] < 23) m[2]++;
    else begin
      m[2] = 0; es[2] = 1;
      m[3] = (m[3] < 6) ? m[3] + 1 : 0;
      if (m[4] < mdays(m[5], m[6])) m[4]++;
      else begin
        m[4] = 1; es[3] = 1;
        if (m[5] < 12) m[5]++;
        else begin
          m[5] = 1;
          m[6] = (m[6] < 99) ? m[6] + 1 : 0;
        end
      end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 7; i++) begin
      addr = 6'(i);
      #1;
      chk(tag, $sformatf("field %0d", i), int'(rdata), m[i]);
    end
  endtask

  task automatic do_op(bit t, bit w, int a, int d, string tag);
    @(negedge clk);
    tick_1hz = t; we = w; addr = 6'(a); wdata = 8'(d);
    @(posedge clk);
    if (w) begin
      es = '{0, 0, 0, 0};
      if (a < 7) m[a] = d;
    end else if (t) model_tick();
    else es = '{0, 0, 0, 0};
    @(negedge clk);
    tick_1hz = 1'b0; we = 1'b0;
    chk("R11", "new_minute", int'(new_minute), es[0]);
    chk("R11", "new_hour",   int'(new_hour),   es[1]);
    chk("R11", "new_day",    int'(new_day),    es[2]);
    chk("R11", "new_month",  int'(new_month),  es[3]);
    check_all(tag);
  endtask

  task automatic set_all(int s, int mi, int h, int dw, int d, int mo, int y, string tag);
    do_op(0, 1, 0, s, tag);  do_op(0, 1, 1, mi, tag); do_op(0, 1, 2, h, tag);
    do_op(0, 1, 3, dw, tag); do_op(0, 1, 4, d, tag);  do_op(0, 1, 5, mo, tag);
    do_op(0, 1, 6, y, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    m = '{0, 0, 0, 0, 1, 1, 0};
    es = '{0, 0, 0, 0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "new_minute", int'(new_minute), 0);
    chk("R1", "new_month", int'(new_month), 0);
    check_all("R1");

    // R3 idle cycles change nothing
    do_op(0, 0, 0, 0, "R3");
    do_op(0, 0, 3, 0, "R3");

    // R2 register map and unmapped addresses
    do_op(0, 1, 1, 42, "R2");
    do_op(0, 1, 9, 77, "R2");
    do_op(0, 1, 63, 5, "R2");
    addr = 6'd9;  #1; chk("R2", "unmapped 9", int'(rdata), 0);
    addr = 6'd63; #1; chk("R2", "unmapped 63", int'(rdata), 0);

    // R4 plain second steps and the full time carry
    do_op(1, 0, 0, 0, "R4");
    set_all(59, 59, 23, 2, 10, 3, 7, "R4");
    do_op(1, 0, 0, 0, "R4");

    // R5 30- and 31-day months
    set_all(59, 59, 23, 0, 30, 4, 5, "R5");
    do_op(1, 0, 0, 0, "R5");
    set_all(59, 59, 23, 0, 30, 1, 5, "R5");
    do_op(1, 0, 0, 0, "R5");
    chk("R5", "jan 31", m[4], 31);

    // R6 February in leap and non-leap years
    set_all(59, 59, 23, 1, 28, 2, 1, "R6");
    do_op(1, 0, 0, 0, "R6");
    chk("R6", "feb 28 non-leap -> mar", m[5], 3);
    set_all(59, 59, 23, 1, 28, 2, 4, "R6");
    do_op(1, 0, 0, 0, "R6");
    chk("R6", "feb 29 leap", m[4], 29);
    do_op(0, 1, 0, 59, "R6"); do_op(0, 1, 1, 59, "R6"); do_op(0, 1, 2, 23, "R6");
    do_op(1, 0, 0, 0, "R6");
    set_all(59, 59, 23, 1, 28, 2, 0, "R6");
    do_op(1, 0, 0, 0, "R6");

    // R7 and R8 year end with day of week wrap
    set_all(59, 59, 23, 6, 31, 12, 99, "R8");
    do_op(1, 0, 0, 0, "R8");
    chk("R7", "dow wrap", m[3], 0);

    // R9 out-of-range values
    set_all(70, 10, 5, 9, 35, 15, 3, "R9");
    do_op(1, 0, 0, 0, "R9");
    do_op(0, 1, 0, 59, "R9"); do_op(0, 1, 1, 200, "R9"); do_op(0, 1, 2, 23, "R9");
    do_op(1, 0, 0, 0, "R9");

    // R10 write colliding with a pulse
    do_op(0, 1, 0, 5, "R10");
    do_op(1, 1, 0, 20, "R10");
    do_op(0, 1, 0, 59, "R10");
    do_op(1, 1, 1, 3, "R10");

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      int r;
      int f;
      int v;
      r = int'($urandom % 10);
      f = int'($urandom % 7);
      v = ($urandom % 4 == 0) ? int'($urandom % 256) :
          ((f == 4) ? 26 + int'($urandom % 6) : int'($urandom % 60));
      if (r < 2)       do_op(0, 1, f, v, "R2");
      else if (r == 9) do_op(1, 1, f, v, "R10");
      else             do_op(1, 0, 0, 0, "R4");
    end
    finish_run();
  end
endmodule